// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small microcontroller core between three operating conditions: full run, idle (CPU clock stopped, everything else alive) and sleep (the whole clock tree, PLL and main oscillator stopped, with only the real-time-clock oscillator optionally left running). Software selects a target condition with a 2-bit request that is committed by a single-cycle execute strobe. Interrupt lines, the non-maskable interrupt and the real-time-clock interrupt bring the core back. Sleep is left through a clock ramp-up wait state, while idle returns to run at once because its clocks never stopped.

While the core rests in idle or sleep, a peripheral event transfer request is honoured without waking the CPU. The sequencer grants the transfer, opens only the clocks the transfer needs, waits for the done acknowledge and then drops back into the low-power condition it came from. Chip-select outputs towards external memory are frozen at their last bus value whenever the bus is quiet, so the last selected device stays selected and every other one stays deselected.

The interrupt controller, the PLL, the real-time-clock counter and the transfer engine sit outside the block. They appear only as request, acknowledge and stable signals. Interrupt lines are expected to stay asserted until they are serviced.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While and right after reset, pm_state is 0 (run), cpu_clk_en, wdt_en, pll_osc_en, periph_clk_en and rtc_osc_en are 1, and xfer_grant and wake_pulse are 0.
- R2: The state codes on pm_state are 0 run, 1 idle, 2 sleep, 3 idle transfer, 4 sleep transfer and 5 wake wait. In run, a cycle with mode_exec high moves to idle for mode_req 01 and to sleep for mode_req 10. mode_req 00 and 11 keep run, and no request takes effect while mode_exec is low. The new state shows one cycle after the strobe.
- R3: A sleep request (10) while sleep_en is 0 is ignored and the core stays in run.
- R4: A wake event (any ext_irq bit, nmi or rtc_irq) in the same cycle as an execute strobe cancels the low-power entry and the core stays in run.
- R5: In idle, only cpu_clk_en is 0. A wake event returns to run in the next cycle with no wait, and wake_pulse is 1 for exactly that one cycle.
- R6: In sleep, cpu_clk_en, wdt_en, pll_osc_en and periph_clk_en are all 0, and rtc_osc_en equals the KEEP_RTC_OSC parameter (default 1).
- R7: Any ext_irq bit, nmi or rtc_irq in sleep moves to wake wait and pulses wake_pulse for one cycle. In wake wait, only pll_osc_en is 1 among the four clock enables.
- R8: Wake wait moves to run in the cycle after clk_stable is seen high. Without clk_stable it moves after exactly ramp_cycles cycles in wake wait, and a ramp_cycles value of 0 counts as 1.
- R9: xfer_req in idle or sleep, with no wake event, enters that mode's transfer state. There xfer_grant, pll_osc_en and periph_clk_en are 1, cpu_clk_en is 0, and wdt_en is 1 from idle and 0 from sleep. xfer_done then returns the core to the originating mode with no wake_pulse.
- R10: cs_n follows bus_cs_n in run and in both transfer states. In idle, sleep and wake wait it holds the last bus value seen in a bus-active state.
- R11: When a wake event and xfer_req arrive together in idle or sleep, the wake is taken and the transfer is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested mode: 00 run, 01 idle, 10 sleep, 11 run |
| mode_exec | input | 1 | Single-cycle strobe that commits mode_req |
| sleep_en | input | 1 | Sleep permission from its own control field |
| ext_irq | input | N_EXT_IRQ | External and alternate-source interrupt lines |
| nmi | input | 1 | Non-maskable interrupt |
| rtc_irq | input | 1 | Real-time-clock interrupt |
| xfer_req | input | 1 | Peripheral event transfer request |
| xfer_done | input | 1 | Transfer complete acknowledge |
| clk_stable | input | 1 | Clock system reports ramp-up finished |
| ramp_cycles | input | RAMP_W | Upper bound on the wake wait length in cycles |
| bus_cs_n | input | N_CS | Active-low chip selects from the bus controller |
| pm_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_en | output | 1 | Watchdog run enable |
| pll_osc_en | output | 1 | PLL and main oscillator enable |
| periph_clk_en | output | 1 | Peripheral and bus clock enable |
| rtc_osc_en | output | 1 | Real-time-clock oscillator enable |
| xfer_grant | output | 1 | Transfer in service |
| wake_pulse | output | 1 | One-cycle wake indication |
| cs_n | output | N_CS | Chip selects towards external devices |

## Verification
Every state-derived output (pm_state, the clock enables, xfer_grant and wake_pulse) is registered. Each is due in the first cycle after the rising edge that samples the stimulus. cs_n is combinational in bus-active states and held otherwise, so it is due in the same window. The bench drives all inputs at the falling edge. Its driver queues the expected outputs for the coming rising edge, and the monitor compares them 2 ns after that edge. A wake wait run is checked step by step, sample by sample, so that its length is observed to equal ramp_cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      PM_RUN        = 3'd0,
      PM_IDLE       = 3'd1,
      PM_SLEEP      = 3'd2,
      PM_IDLE_XFER  = 3'd3,
      PM_SLEEP_XFER = 3'd4,
      PM_WAKE_WAIT  = 3'd5
   } pm_state_e;

   localparam logic [1:0] MREQ_IDLE  = 2'b01;
   localparam logic [1:0] MREQ_SLEEP = 2'b10;

   typedef struct packed {
      logic cpu;
      logic wdt;
      logic pll;
      logic periph;
   } clk_en_t;

   // Clock enables as a pure function of the state.
   function automatic clk_en_t pm_clk_decode(input pm_state_e s);
      clk_en_t e;
      case (s)
         PM_RUN:        e = '{cpu: 1'b1, wdt: 1'b1, pll: 1'b1, periph: 1'b1};
         PM_IDLE,
         PM_IDLE_XFER:  e = '{cpu: 1'b0, wdt: 1'b1, pll: 1'b1, periph: 1'b1};
         PM_SLEEP:      e = '{cpu: 1'b0, wdt: 1'b0, pll: 1'b0, periph: 1'b0};
         PM_SLEEP_XFER: e = '{cpu: 1'b0, wdt: 1'b0, pll: 1'b1, periph: 1'b1};
         PM_WAKE_WAIT:  e = '{cpu: 1'b0, wdt: 1'b0, pll: 1'b1, periph: 1'b0};
         default:       e = '{cpu: 1'b1, wdt: 1'b1, pll: 1'b1, periph: 1'b1};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/pmc_wake_merge.sv
module pmc_wake_merge #(
   parameter int N_EXT_IRQ   = 4,
   parameter bit RTC_WAKE_EN = 1'b1
) (
   input  logic [N_EXT_IRQ-1:0] ext_irq,
   input  logic                 nmi,
   input  logic                 rtc_irq,
   output logic                 wake_evt
);
   logic rtc_term;

   generate
      if (RTC_WAKE_EN) begin : g_rtc_wake
         assign rtc_term = rtc_irq;
      end else begin : g_rtc_masked
         assign rtc_term = 1'b0;
      end
   endgenerate

   assign wake_evt = (|ext_irq) | nmi | rtc_term;
endmodule

// File: rtl/pmc_ramp_timer.sv
module pmc_ramp_timer #(
   parameter int RAMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [RAMP_W-1:0] limit,
   output logic              expired
);
   localparam int          EXT_W = RAMP_W + 1;
   localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

   logic [RAMP_W-1:0] cnt_q;
   logic [EXT_W-1:0]  cnt_next_ext;

   assign cnt_next_ext = {1'b0, cnt_q} + ONE;
   // Cycle count including the current one has reached the limit (0 acts as 1).
   assign expired = cnt_next_ext >= {1'b0, limit};

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_next_ext[RAMP_W-1:0];
      end
   end
endmodule

// File: rtl/pmc_cs_hold.sv
module pmc_cs_hold #(
   parameter int N_CS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_live,
   input  logic [N_CS-1:0] bus_cs_n,
   output logic [N_CS-1:0] cs_n
);
   generate
      for (genvar i = 0; i < N_CS; i++) begin : g_lane
         logic held_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q <= 1'b1;
            end else if (bus_live) begin
               held_q <= bus_cs_n[i];
            end
         end
         assign cs_n[i] = bus_live ? bus_cs_n[i] : held_q;
      end
   endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
   parameter int N_EXT_IRQ    = 4,
   parameter int N_CS         = 4,
   parameter int RAMP_W       = 8,
   parameter bit KEEP_RTC_OSC = 1'b1,
   parameter bit RTC_WAKE_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_req,
   input  logic                 mode_exec,
   input  logic                 sleep_en,
   input  logic [N_EXT_IRQ-1:0] ext_irq,
   input  logic                 nmi,
   input  logic                 rtc_irq,
   input  logic                 xfer_req,
   input  logic                 xfer_done,
   input  logic                 clk_stable,
   input  logic [RAMP_W-1:0]    ramp_cycles,
   input  logic [N_CS-1:0]      bus_cs_n,
   output logic [2:0]           pm_state,
   output logic                 cpu_clk_en,
   output logic                 wdt_en,
   output logic                 pll_osc_en,
   output logic                 periph_clk_en,
   output logic                 rtc_osc_en,
   output logic                 xfer_grant,
   output logic                 wake_pulse,
   output logic [N_CS-1:0]      cs_n
);
   import pmc_pkg::*;

   generate
      if (N_EXT_IRQ < 1) begin : g_bad_irq
         $error("pwr_mode_ctrl: N_EXT_IRQ must be at least 1");
      end
      if (N_CS < 1) begin : g_bad_cs
         $error("pwr_mode_ctrl: N_CS must be at least 1");
      end
      if (RAMP_W < 1 || RAMP_W > 16) begin : g_bad_ramp
         $error("pwr_mode_ctrl: RAMP_W must lie in 1..16");
      end
   endgenerate

   pm_state_e state_q, state_d;
   logic      wake_evt;
   logic      ramp_expired;
   logic      wake_q;
   logic      bus_live;
   logic      rest_state;
   clk_en_t   en;

   pmc_wake_merge #(
      .N_EXT_IRQ  (N_EXT_IRQ),
      .RTC_WAKE_EN(RTC_WAKE_EN)
   ) u_wake (
      .ext_irq (ext_irq),
      .nmi     (nmi),
      .rtc_irq (rtc_irq),
      .wake_evt(wake_evt)
   );

   pmc_ramp_timer #(
      .RAMP_W(RAMP_W)
   ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == PM_WAKE_WAIT),
      .limit  (ramp_cycles),
      .expired(ramp_expired)
   );

   assign bus_live   = (state_q == PM_RUN) || (state_q == PM_IDLE_XFER) ||
                       (state_q == PM_SLEEP_XFER);
   assign rest_state = (state_q == PM_IDLE) || (state_q == PM_SLEEP);

   pmc_cs_hold #(
      .N_CS(N_CS)
   ) u_cs (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_live(bus_live),
      .bus_cs_n(bus_cs_n),
      .cs_n    (cs_n)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         PM_RUN: begin
            if (mode_exec && !wake_evt) begin
               if (mode_req == MREQ_IDLE) begin
                  state_d = PM_IDLE;
               end else if (mode_req == MREQ_SLEEP && sleep_en) begin
                  state_d = PM_SLEEP;
               end
            end
         end
         PM_IDLE: begin
            if (wake_evt)      state_d = PM_RUN;
            else if (xfer_req) state_d = PM_IDLE_XFER;
         end
         PM_IDLE_XFER: begin
            if (xfer_done) state_d = PM_IDLE;
         end
         PM_SLEEP: begin
            if (wake_evt)      state_d = PM_WAKE_WAIT;
            else if (xfer_req) state_d = PM_SLEEP_XFER;
         end
         PM_SLEEP_XFER: begin
            if (xfer_done) state_d = PM_SLEEP;
         end
         PM_WAKE_WAIT: begin
            if (clk_stable || ramp_expired) state_d = PM_RUN;
         end
         default: state_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PM_RUN;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         wake_q  <= rest_state && wake_evt;
      end
   end

   assign en            = pm_clk_decode(state_q);
   assign cpu_clk_en    = en.cpu;
   assign wdt_en        = en.wdt;
   assign pll_osc_en    = en.pll;
   assign periph_clk_en = en.periph;
   assign rtc_osc_en    = (state_q == PM_SLEEP) ? KEEP_RTC_OSC : 1'b1;
   assign xfer_grant    = (state_q == PM_IDLE_XFER) || (state_q == PM_SLEEP_XFER);
   assign wake_pulse    = wake_q;
   assign pm_state      = state_q;

   AST_SLEEP_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && mode_exec && mode_req == MREQ_SLEEP && !sleep_en)
      |=> (pm_state == 3'd0)) else $error("sleep entered without permission"); // R3

   AST_CANCEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && mode_exec && wake_evt) |=> cpu_clk_en)
      else $error("entry not cancelled by wake"); // R4

   AST_IDLE_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_IDLE && wake_evt) |=> (cpu_clk_en && wake_pulse))
      else $error("idle exit delayed"); // R5

   AST_SLEEP_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_SLEEP && wake_evt) |=> (pll_osc_en && !cpu_clk_en && wake_pulse))
      else $error("sleep wake did not enter ramp wait"); // R7

   AST_RAMP_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_WAKE_WAIT && !clk_stable && !ramp_expired) |=> !cpu_clk_en)
      else $error("CPU restarted before ramp-up"); // R8

   AST_XFER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_SLEEP_XFER && xfer_done) |=> (!pll_osc_en && !xfer_grant && !wake_pulse))
      else $error("sleep transfer did not fall back"); // R9

   AST_CPU_XFER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_clk_en, xfer_grant})) else $error("CPU clocked during transfer"); // R9

   AST_CS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_live && $past(!bus_live)) |-> $stable(cs_n))
      else $error("chip selects moved while bus quiet"); // R10

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd1, S_SLEEP = 3'd2,
                          S_IX = 3'd3, S_SX = 3'd4, S_WW = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_req;
   logic       mode_exec, sleep_en, nmi, rtc_irq, xfer_req, xfer_done, clk_stable;
   logic [3:0] ext_irq;
   logic [7:0] ramp_cycles;
   logic [3:0] bus_cs_n;
   logic [2:0] pm_state;
   logic       cpu_clk_en, wdt_en, pll_osc_en, periph_clk_en, rtc_osc_en;
   logic       xfer_grant, wake_pulse;
   logic [3:0] cs_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [14:0] q_v[$];
   string       q_tag[$];

   always #4 clk = ~clk;

   pwr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_exec(mode_exec),
      .sleep_en(sleep_en), .ext_irq(ext_irq), .nmi(nmi), .rtc_irq(rtc_irq),
      .xfer_req(xfer_req), .xfer_done(xfer_done), .clk_stable(clk_stable),
      .ramp_cycles(ramp_cycles), .bus_cs_n(bus_cs_n), .pm_state(pm_state),
      .cpu_clk_en(cpu_clk_en), .wdt_en(wdt_en), .pll_osc_en(pll_osc_en),
      .periph_clk_en(periph_clk_en), .rtc_osc_en(rtc_osc_en),
      .xfer_grant(xfer_grant), .wake_pulse(wake_pulse), .cs_n(cs_n));

   // Expected enables per state, from R1/R5/R6/R7/R9: {cpu,wdt,pll,periph,rtc,grant}
   function automatic logic [5:0] en_of(input logic [2:0] s);
      case (s)
         S_RUN:   return 6'b111110;
         S_IDLE:  return 6'b011110;
         S_SLEEP: return 6'b000010;
         S_IX:    return 6'b011111;
         S_SX:    return 6'b001111;
         S_WW:    return 6'b001010;
         default: return 6'b000000;
      endcase
   endfunction

   task automatic clr();
      mode_exec = 1'b0; ext_irq = '0; nmi = 1'b0; rtc_irq = 1'b0;
      xfer_req = 1'b0; xfer_done = 1'b0; clk_stable = 1'b0;
   endtask

   // Driver: queue expectation for the coming edge, then move to the next falling edge.
   task automatic chk(input logic [2:0] s, input logic wk, input logic [3:0] cs, input string tag);
      q_v.push_back({s, en_of(s), wk, cs});
      q_tag.push_back(tag);
      @(posedge clk);
      #4;
   endtask

   // Monitor: compares 2 ns after each rising edge.
   always @(posedge clk) begin
      #2;
      if (q_v.size() > 0) begin
         logic [14:0] e, a;
         string t;
         e = q_v.pop_front();
         t = q_tag.pop_front();
         a = {pm_state, cpu_clk_en, wdt_en, pll_osc_en, periph_clk_en, rtc_osc_en,
              xfer_grant, wake_pulse, cs_n};
         checks++;
         if (a !== e) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", t, a, e);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; clr(); mode_req = 2'b00; sleep_en = 1'b1;
      ramp_cycles = 8'd3; bus_cs_n = 4'b1110;
      @(negedge clk);
      chk(S_RUN, 0, 4'b1110, "R1 in reset");
      rst_n = 1'b1;
      chk(S_RUN, 0, 4'b1110, "R1 after reset");
      // R2 encodings
      clr(); mode_req = 2'b00; mode_exec = 1; chk(S_RUN, 0, 4'b1110, "R2 req 00");
      clr(); mode_req = 2'b11; mode_exec = 1; chk(S_RUN, 0, 4'b1110, "R2 req 11");
      clr(); mode_req = 2'b01;                chk(S_RUN, 0, 4'b1110, "R2 no strobe");
      clr(); mode_req = 2'b01; mode_exec = 1; chk(S_IDLE, 0, 4'b1110, "R2 idle entry");
      clr(); bus_cs_n = 4'b0111;              chk(S_IDLE, 0, 4'b1110, "R10 idle hold");
      // R9 idle transfer
      clr(); xfer_req = 1;                    chk(S_IX, 0, 4'b0111, "R9 idle xfer grant");
      clr();                                  chk(S_IX, 0, 4'b0111, "R9 wait done");
      clr(); xfer_done = 1;                   chk(S_IDLE, 0, 4'b0111, "R9 back to idle");
      // R5 idle wake
      clr(); ext_irq = 4'b0100;               chk(S_RUN, 1, 4'b0111, "R5 idle wake");
      clr();                                  chk(S_RUN, 0, 4'b0111, "R5 single pulse");
      // R3 / R4
      clr(); sleep_en = 0; mode_req = 2'b10; mode_exec = 1; chk(S_RUN, 0, 4'b0111, "R3 sleep denied");
      clr(); sleep_en = 1; mode_req = 2'b10; mode_exec = 1; nmi = 1;
      chk(S_RUN, 0, 4'b0111, "R4 nmi cancels sleep entry");
      // R6 sleep
      clr(); mode_req = 2'b10; mode_exec = 1; chk(S_SLEEP, 0, 4'b0111, "R6 sleep entry");
      clr(); bus_cs_n = 4'b1011;              chk(S_SLEEP, 0, 4'b0111, "R10 sleep hold");
      clr(); xfer_req = 1;                    chk(S_SX, 0, 4'b1011, "R9 sleep xfer");
      clr(); xfer_done = 1;                   chk(S_SLEEP, 0, 4'b1011, "R9 back to sleep");
      // R11 wake beats transfer, then R8 ramp of 3 cycles
      clr(); xfer_req = 1; ext_irq = 4'b0001; chk(S_WW, 1, 4'b1011, "R11 wake over xfer");
      clr();                                  chk(S_WW, 0, 4'b1011, "R8 ramp cycle 2");
      clr();                                  chk(S_WW, 0, 4'b1011, "R8 ramp cycle 3");
      clr();                                  chk(S_RUN, 0, 4'b1011, "R8 ramp expiry");
      // R7 other sources, R8 early stable
      clr(); mode_req = 2'b10; mode_exec = 1; chk(S_SLEEP, 0, 4'b1011, "R6 sleep again");
      clr(); rtc_irq = 1;                     chk(S_WW, 1, 4'b1011, "R7 rtc wake");
      clr(); clk_stable = 1;                  chk(S_RUN, 0, 4'b1011, "R8 stable exit");
      clr(); mode_req = 2'b10; mode_exec = 1; chk(S_SLEEP, 0, 4'b1011, "R6 sleep third");
      clr(); nmi = 1;                         chk(S_WW, 1, 4'b1011, "R7 nmi wake");
      clr(); clk_stable = 1;                  chk(S_RUN, 0, 4'b1011, "R8 stable exit 2");
      // more idle corners
      clr(); mode_req = 2'b01; mode_exec = 1; chk(S_IDLE, 0, 4'b1011, "R2 idle again");
      clr(); rtc_irq = 1;                     chk(S_RUN, 1, 4'b1011, "R5 rtc idle wake");
      clr(); mode_req = 2'b01; mode_exec = 1; chk(S_IDLE, 0, 4'b1011, "R2 idle third");
      clr(); xfer_req = 1; ext_irq = 4'b0010; chk(S_RUN, 1, 4'b1011, "R11 idle wake over xfer");
      clr(); mode_req = 2'b01; mode_exec = 1; ext_irq = 4'b1000;
      chk(S_RUN, 0, 4'b1011, "R4 irq cancels idle entry");
      clr();
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule